// File: doc/BRIEF.md
# BIST Packet Pattern Checker

This block sits on one receive lane during a built-in self test. It watches the incoming symbol stream for a marker control symbol. Once it sees the marker it treats the following data symbols as one packet's payload and compares each of them against a locally regenerated PRBS7 sequence. A new marker starts a new packet and reseeds the sequence.

Two 16-bit saturating counters track the run: one counts packets (markers accepted) and one counts payload symbols that mismatched. Three flags summarise the run: sync, a sticky error flag, and pass. The enable input lets the checker run or freezes it so its results can be read afterwards. The clear input is a toggle: any change of its level wipes the checker's state, so software clears it by writing back the inverse of the value it read.

Top module: `bist_pkt_checker`

## Requirements
- R1: After reset, sync, err and pass are 0, and pkt_cnt and err_cnt are 0.
- R2: An accepted marker (sym_valid=1, sym_k=1, sym=8'hBC) sets sync. Until sync is set, every data symbol is ignored and no error is counted.
- R3: After each marker, the next 8 data symbols (sym_k=0) are compared with PRBS7 reseeded to 7'h7F. Each PRBS step computes f = s[6]^s[5] and sets s = {s[5:0], f}. Each expected byte is made of 8 successive values of f, placed from the MSB down. Each mismatching symbol adds one to err_cnt and sets err, and err stays set. Data symbols that arrive after the 8th one and before the next marker are ignored, and so are control symbols other than the marker.
- R4: pkt_cnt increases by one for every accepted marker. A run of 15 correct packets reads 15.
- R5: pkt_cnt and err_cnt saturate at 16'hFFFF.
- R6: pass is 1 exactly when sync is 1, err is 0, pkt_cnt is at least 1 and the last packet has received all 8 payload symbols.
- R7: A marker that arrives before the current payload is complete starts a new packet. The symbols already checked keep their results.
- R8: A change in the level of clr_tgl, sampled at a clock edge, returns all state to its reset value at that edge. It takes priority over a symbol presented in the same cycle.
- R9: While en is 0, all symbols are ignored and every output holds its value.
- R10: A cycle with sym_valid=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Checker enable |
| clr_tgl | input | 1 | Clear control; any level change clears |
| sym_valid | input | 1 | Symbol strobe |
| sym_k | input | 1 | 1 for a control symbol, 0 for data |
| sym | input | 8 | Received symbol |
| sync | output | 1 | Marker seen since the last clear |
| err | output | 1 | Sticky mismatch flag |
| pass | output | 1 | Run judged good |
| pkt_cnt | output | 16 | Saturating packet count |
| err_cnt | output | 16 | Saturating mismatch count |

## Verification
A clear toggle can land in the same cycle as an incoming symbol, either a marker or a corrupt payload byte, and the clear must win. The bench toggles clr_tgl while it presents a marker, and again while it presents a mismatching payload byte. The behavioural model then expects all-zero state and no count from that symbol. Saturation meets new events in the same way: markers and bad bytes keep arriving while the counters are pinned at 16'hFFFF, and the model expects the counters to hold.

// File: rtl/bist_pkt_checker.sv
module bist_pkt_checker #(
  parameter int SYM_W       = 8,
  parameter logic [SYM_W-1:0] MARKER = 8'hBC,
  parameter int PAYLOAD_LEN = 8,
  parameter int CNT_W       = 16,
  parameter logic [6:0] SEED = 7'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr_tgl,
  input  logic             sym_valid,
  input  logic             sym_k,
  input  logic [SYM_W-1:0] sym,
  output logic             sync,
  output logic             err,
  output logic             pass,
  output logic [CNT_W-1:0] pkt_cnt,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int IDX_W = $clog2(PAYLOAD_LEN + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAYLOAD_LEN);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             clr_q, sync_q, err_q;
  logic [IDX_W-1:0] idx_q;
  logic [6:0]       lfsr_q, lfsr_nx;
  logic [SYM_W-1:0] exp_sym;
  logic [CNT_W-1:0] pkt_q, errc_q;

  wire clr_evt  = clr_tgl ^ clr_q;
  wire take     = en && sym_valid;
  wire is_mark  = take && sym_k && (sym == MARKER);
  wire is_data  = take && !sym_k && sync_q && (idx_q != LAST);
  wire mismatch = is_data && (sym != exp_sym);

  always_comb begin
    logic [6:0] st;
    logic       fb;
    st = lfsr_q;
    exp_sym = '0;
    for (int i = 0; i < SYM_W; i++) begin
      fb = st[6] ^ st[5];
      st = {st[5:0], fb};
      exp_sym[SYM_W-1-i] = fb;
    end
    lfsr_nx = st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      sync_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      lfsr_q <= SEED;
      pkt_q  <= '0;
      errc_q <= '0;
    end else begin
      clr_q <= clr_tgl;
      if (clr_evt) begin
        sync_q <= 1'b0;
        err_q  <= 1'b0;
        idx_q  <= '0;
        lfsr_q <= SEED;
        pkt_q  <= '0;
        errc_q <= '0;
      end else if (is_mark) begin
        sync_q <= 1'b1;
        idx_q  <= '0;
        lfsr_q <= SEED;
        if (pkt_q != CMAX) pkt_q <= pkt_q + CNT_W'(1);
      end else if (is_data) begin
        idx_q  <= idx_q + IDX_W'(1);
        lfsr_q <= lfsr_nx;
        if (mismatch) begin
          err_q <= 1'b1;
          if (errc_q != CMAX) errc_q <= errc_q + CNT_W'(1);
        end
      end
    end
  end

  assign sync    = sync_q;
  assign err     = err_q;
  assign pkt_cnt = pkt_q;
  assign err_cnt = errc_q;
  assign pass    = sync_q && !err_q && (pkt_q != '0) && (idx_q == LAST);

  assert_presync_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |-> (err_cnt == '0 && !err && pkt_cnt == '0));
  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_evt) |=> err);
  assert_errcnt_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '0) |-> err);
  assert_pkt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt == CMAX && !clr_evt) |=> pkt_cnt == CMAX);
  assert_err_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == CMAX && !clr_evt) |=> err_cnt == CMAX);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (!sync && !err && pkt_cnt == '0 && err_cnt == '0));
  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr_evt) |=> ($stable(pkt_cnt) && $stable(err_cnt) && $stable(sync) && $stable(pass)));
endmodule

// File: tb/bist_pkt_checker_tb.sv
module bist_pkt_checker_tb;
  localparam int LEN = 8;
  localparam logic [7:0] MARK = 8'hBC;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr_tgl = 1'b0;
  logic sym_valid = 1'b0, sym_k = 1'b0;
  logic [7:0] sym = 8'h00;
  logic sync, err, pass;
  logic [15:0] pkt_cnt, err_cnt;

  int checks = 0, errors = 0, cycles = 0;
  string ph = "R1";
  bit done = 1'b0;

  bit m_sync, m_err, m_clr;
  int m_idx, m_pkt, m_errc;

  always #4 clk = ~clk;

  bist_pkt_checker u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr_tgl(clr_tgl),
    .sym_valid(sym_valid), .sym_k(sym_k), .sym(sym),
    .sync(sync), .err(err), .pass(pass), .pkt_cnt(pkt_cnt), .err_cnt(err_cnt)
  );

  function automatic logic [7:0] pay_byte(int k);
    logic [6:0] st = 7'h7F;
    logic [7:0] b = 8'h00;
    logic fb;
    for (int i = 0; i <= k; i++)
      for (int j = 0; j < 8; j++) begin
        fb = st[6] ^ st[5];
        st = {st[5:0], fb};
        b = {b[6:0], fb};
      end
    return b;
  endfunction

  function automatic bit m_pass();
    return m_sync && !m_err && m_pkt > 0 && m_idx == LEN;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (phase %s) at cycle %0d: actual=%0h expected=%0h", tag, ph, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_sync = 0; m_err = 0; m_clr = 0; m_idx = 0; m_pkt = 0; m_errc = 0;
    end else begin
      if (clr_tgl != m_clr) begin
        m_sync = 0; m_err = 0; m_idx = 0; m_pkt = 0; m_errc = 0;
      end else if (en && sym_valid) begin
        if (sym_k && sym == MARK) begin
          m_sync = 1; m_idx = 0;
          if (m_pkt < 65535) m_pkt++;
        end else if (!sym_k && m_sync && m_idx < LEN) begin
          if (sym != pay_byte(m_idx)) begin
            m_err = 1;
            if (m_errc < 65535) m_errc++;
          end
          m_idx++;
        end
      end
      m_clr = clr_tgl;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(sync == m_sync, "R2 sync", sync, m_sync);
    chk(err == m_err, "R3 err", err, m_err);
    chk(err_cnt == m_errc, "R3 err_cnt", err_cnt, m_errc);
    chk(pkt_cnt == m_pkt, "R4 pkt_cnt", pkt_cnt, m_pkt);
    chk(pass == m_pass(), "R6 pass", pass, m_pass());
  end

  task automatic put(bit v, bit k, logic [7:0] s);
    @(negedge clk);
    sym_valid = v; sym_k = k; sym = s;
  endtask

  task automatic packet(int nbytes, logic [7:0] flip, int badpos);
    put(1, 1, MARK);
    for (int i = 0; i < nbytes; i++)
      put(1, 0, (badpos < 0 || badpos == i) ? pay_byte(i) ^ flip : pay_byte(i));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sync == 0 && err == 0 && pass == 0, "R1 flags", {sync, err, pass}, 0);
    chk(pkt_cnt == 0 && err_cnt == 0, "R1 counts", {pkt_cnt, err_cnt}, 0);
    rst_n = 1'b1;
    en = 1'b1;

    ph = "R2 presync";
    for (int i = 0; i < 10; i++) put(1, 0, 8'(i * 37));
    put(1, 1, 8'h1C);
    put(0, 0, 8'h00);
    chk(err_cnt == 0 && sync == 0, "R2 presync ignored", err_cnt, 0);

    ph = "R4 good run";
    for (int p = 0; p < 15; p++) begin
      packet(LEN, 8'h00, 0);
      if (p % 3 == 0) put(0, 0, 8'h55);
      if (p % 4 == 1) put(1, 0, 8'hAA);
      if (p % 5 == 2) put(1, 1, 8'hF7);
    end
    put(0, 0, 8'h00);
    chk(pkt_cnt == 15, "R4 default count", pkt_cnt, 15);
    chk(pass == 1, "R6 pass after clean run", pass, 1);

    ph = "R10 gaps";
    put(1, 1, MARK);
    for (int i = 0; i < LEN; i++) begin
      put(0, 0, 8'hFF);
      put(1, 0, pay_byte(i));
    end
    put(0, 0, 8'h00);
    chk(err_cnt == 0 && pass == 1, "R10 invalid cycles ignored", err_cnt, 0);

    ph = "R3 mismatch";
    packet(LEN, 8'h01, 3);
    put(0, 0, 8'h00);
    chk(err_cnt == 1 && err == 1 && pass == 0, "R3 single mismatch", err_cnt, 1);
    packet(LEN, 8'h00, 0);
    put(0, 0, 8'h00);
    chk(err == 1, "R3 err sticky", err, 1);

    ph = "R8 clear with marker";
    @(negedge clk);
    sym_valid = 1; sym_k = 1; sym = MARK; clr_tgl = ~clr_tgl;
    put(0, 0, 8'h00);
    chk(pkt_cnt == 0 && sync == 0 && err == 0, "R8 clear wins over marker", pkt_cnt, 0);

    ph = "R8 clear with bad byte";
    put(1, 1, MARK);
    @(negedge clk);
    sym_valid = 1; sym_k = 0; sym = ~pay_byte(0); clr_tgl = ~clr_tgl;
    put(0, 0, 8'h00);
    chk(err_cnt == 0 && sync == 0, "R8 clear wins over mismatch", err_cnt, 0);

    ph = "R7 restart";
    packet(3, 8'h00, 0);
    packet(LEN, 8'h00, 0);
    put(0, 0, 8'h00);
    chk(pkt_cnt == 2 && err_cnt == 0 && pass == 1, "R7 restart mid payload", pkt_cnt, 2);
    packet(5, 8'h00, 0);
    put(0, 0, 8'h00);
    chk(pass == 0, "R6 short last packet", pass, 0);

    ph = "R9 disabled";
    en = 1'b0;
    packet(LEN, 8'hFF, -1);
    put(0, 0, 8'h00);
    chk(pkt_cnt == 3 && err_cnt == 0, "R9 disabled ignores stream", pkt_cnt, 3);
    en = 1'b1;

    ph = "R5 pkt saturation";
    for (int i = 0; i < 65540; i++) put(1, 1, MARK);
    put(0, 0, 8'h00);
    chk(pkt_cnt == 16'hFFFF, "R5 pkt_cnt saturates", pkt_cnt, 16'hFFFF);

    ph = "R5 err saturation";
    @(negedge clk);
    clr_tgl = ~clr_tgl; sym_valid = 0;
    for (int p = 0; p < 8200; p++) packet(LEN, 8'hFF, -1);
    put(0, 0, 8'h00);
    chk(err_cnt == 16'hFFFF, "R5 err_cnt saturates", err_cnt, 16'hFFFF);
    chk(pkt_cnt == 8200, "R4 count after clear", pkt_cnt, 8200);

    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    wait (cycles > 190000);
    @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (phase %s): actual=%0d expected=<190000 cycles", ph, cycles);
      finish_run();
    end
  end
endmodule